// File: doc/BRIEF.md
# Configuration Security Access Controller

This block is the configuration-access side of a small programmable-logic device. A single command port lets a programmer enter and leave a programming session, erase the whole configuration array, write and read back configuration words, write and read a 16-bit user signature, and set a security fuse. The configuration array is a set of internal registers. The block drives one global I/O enable that tells the user logic whether its pins may drive.

The fuse stops configuration readback. It does not restrict the user signature. Only an erase of the whole array clears the fuse. If a session that has begun to modify state is cut short, the block enters a locked state and the user I/O stays released. The cut can be a warm reset, an abort, or an exit while a write is still in flight. Only a fresh erase, at least one completed word write and a clean exit clear the lock.

There are two resets. `por_n` is asynchronous and models power-up. It sets the array to all ones, clears the signature, fuse and lock, and selects functional mode. `rst_n` is a synchronous warm reset. It ends any session but keeps the array, the signature and the fuse.

Top module: `cfg_sec_ctrl`

## Requirements
- R1: A verify command (opcode 5) accepted in programming mode while the fuse is set returns rsp_data = 0 with rsp_err = 1, one cycle after the command.
- R2: Signature write (opcode 6) and signature read (opcode 7) work whatever the fuse state. Signature read is also served in functional mode.
- R3: The fuse is set by opcode 8 and cleared only by bulk erase (opcode 3). Word writes and signature writes leave it set.
- R4: io_enable is low for the whole of programming mode, entered by opcode 1. After a clean exit (opcode 2) with no lock, io_enable is high.
- R5: The block sets locked, leaves programming mode and keeps io_enable low in three cases. The first is a warm reset during a session that has issued a modifying command (erase, write, signature write or fuse set). The second is an abort in such a session. The third is an exit while a word write is still outstanding. An abort in an unmodified session returns to functional mode without a lock.
- R6: The lock survives exits. It clears only on a clean exit from a session in which a bulk erase was followed by a completed word write.
- R7: In functional mode every command except opcodes 1 and 7 is ignored. Undefined opcodes (0, 9 to 15) and opcode 1 issued in programming mode are also ignored. An ignored command produces rsp_valid with rsp_ign = 1 and changes no state.
- R8: Power-up and bulk erase both leave every configuration word reading 16'hFFFF and the fuse clear. Bulk erase keeps the signature.
- R9: A word write (opcode 4, word index in cmd_addr) lands WR_CYC cycles after acceptance. wr_busy is high until then. Commands other than exit that arrive while wr_busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| rst_n | input | 1 | Synchronous warm reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | AW | Configuration word index |
| cmd_wdata | input | DW | Write data for word or signature |
| abort | input | 1 | Abandon the current session |
| rsp_valid | output | 1 | Response strobe, one cycle after a command |
| rsp_data | output | DW | Read data, zero when not a read |
| rsp_err | output | 1 | Verify refused by the fuse |
| rsp_ign | output | 1 | Command was ignored |
| prog_mode | output | 1 | Programming session active |
| io_enable | output | 1 | Global user I/O enable |
| fuse_set | output | 1 | Security fuse state |
| locked | output | 1 | Interrupted-session lock |
| wr_busy | output | 1 | Word write outstanding |

## Verification
Each command response appears on the outputs right after the clock edge that accepts the command. The mode, fuse, lock and I/O-enable changes it causes appear at that same edge. A word write reaches the array WR_CYC edges after the accepting edge, and a warm reset shows its effect on locked at the edge where rst_n is sampled low. The bench changes inputs on the falling edge and reads results at the next falling edge. For writes it reads wr_busy at once and waits exactly WR_CYC further falling edges before it checks that the write has finished and verifies the word.

// File: rtl/cfg_sec_ctrl.sv
module cfg_sec_ctrl #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int WR_CYC = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          abort,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          rsp_ign,
  output logic          prog_mode,
  output logic          io_enable,
  output logic          fuse_set,
  output logic          locked,
  output logic          wr_busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WR_CYC + 1);
  localparam logic [3:0] OP_ENTER = 4'd1, OP_EXIT = 4'd2, OP_ERASE = 4'd3,
                         OP_WRITE = 4'd4, OP_VERIFY = 4'd5, OP_SIGWR = 4'd6,
                         OP_SIGRD = 4'd7, OP_FUSE = 4'd8;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] sig, pend_data;
  logic [AW-1:0] pend_addr;
  logic [CW-1:0] cnt;
  logic          dirty;
  logic [1:0]    stage;

  assign wr_busy   = (cnt != '0);
  assign io_enable = !prog_mode && !locked;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      sig       <= '0;
      pend_data <= '0;
      pend_addr <= '0;
      cnt       <= '0;
      fuse_set  <= 1'b0;
      locked    <= 1'b0;
      prog_mode <= 1'b0;
      dirty     <= 1'b0;
      stage     <= 2'd0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_ign   <= 1'b0;
    end else if (!rst_n) begin
      locked    <= locked | (prog_mode & dirty);
      prog_mode <= 1'b0;
      dirty     <= 1'b0;
      stage     <= 2'd0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_ign   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_ign   <= 1'b0;
      if (wr_busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          mem[pend_addr] <= pend_data;
          if (stage == 2'd1) stage <= 2'd2;
        end
      end
      if (prog_mode && abort) begin
        prog_mode <= 1'b0;
        cnt       <= '0;
        if (dirty) locked <= 1'b1;
        dirty     <= 1'b0;
        stage     <= 2'd0;
      end else if (cmd_valid) begin
        rsp_valid <= 1'b1;
        if (!prog_mode) begin
          case (cmd_op)
            OP_ENTER: begin
              prog_mode <= 1'b1;
              dirty     <= 1'b0;
              stage     <= 2'd0;
            end
            OP_SIGRD: rsp_data <= sig;
            default:  rsp_ign  <= 1'b1;
          endcase
        end else if (wr_busy && cmd_op != OP_EXIT) begin
          rsp_ign <= 1'b1;
        end else begin
          case (cmd_op)
            OP_EXIT: begin
              prog_mode <= 1'b0;
              cnt       <= '0;
              if (wr_busy) locked <= 1'b1;
              else if (stage == 2'd2) locked <= 1'b0;
              dirty     <= 1'b0;
              stage     <= 2'd0;
            end
            OP_ERASE: begin
              for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
              fuse_set <= 1'b0;
              dirty    <= 1'b1;
              if (locked) stage <= 2'd1;
            end
            OP_WRITE: begin
              pend_addr <= cmd_addr;
              pend_data <= cmd_wdata;
              cnt       <= CW'(WR_CYC);
              dirty     <= 1'b1;
            end
            OP_VERIFY: begin
              if (fuse_set) rsp_err <= 1'b1;
              else rsp_data <= mem[cmd_addr];
            end
            OP_SIGWR: begin
              sig   <= cmd_wdata;
              dirty <= 1'b1;
            end
            OP_SIGRD: rsp_data <= sig;
            OP_FUSE: begin
              fuse_set <= 1'b1;
              dirty    <= 1'b1;
            end
            default: rsp_ign <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_sec_ctrl_chk.sv
module cfg_sec_ctrl_chk #(parameter int DW = 16) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          abort,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_err,
  input logic          rsp_ign,
  input logic          prog_mode,
  input logic          io_enable,
  input logic          fuse_set,
  input logic          locked,
  input logic          wr_busy,
  input logic          dirty
);
  AST_VERIFY_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && cmd_valid && cmd_op == 4'd5 && prog_mode && !abort && !wr_busy && fuse_set)
    |=> (rsp_err && rsp_data == '0)); // R1
  AST_SIG_FUNC_READ: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && cmd_valid && cmd_op == 4'd7 && !prog_mode) |=> (rsp_valid && !rsp_ign)); // R2
  AST_FUSE_CLEAR_SRC: assert property (@(posedge clk) disable iff (!por_n)
    $fell(fuse_set) |-> $past(rst_n && cmd_valid && cmd_op == 4'd3 && prog_mode && !abort)); // R3
  AST_ENTER_IO_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && cmd_valid && cmd_op == 4'd1 && !prog_mode) |=> (prog_mode && !io_enable)); // R4
  AST_RST_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && prog_mode && dirty) |=> (locked && !io_enable)); // R5
  AST_ABORT_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && abort && prog_mode && dirty) |=> (locked && !prog_mode)); // R5
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(locked) |-> $past(rst_n && cmd_valid && cmd_op == 4'd2 && prog_mode && !abort && !wr_busy)); // R6
  AST_FUNC_IGNORE: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && cmd_valid && !prog_mode && cmd_op != 4'd1 && cmd_op != 4'd7) |=> rsp_ign); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && cmd_valid && prog_mode && !abort && wr_busy && cmd_op != 4'd2) |=> rsp_ign); // R9
endmodule

bind cfg_sec_ctrl cfg_sec_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .abort(abort), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .rsp_ign(rsp_ign), .prog_mode(prog_mode), .io_enable(io_enable), .fuse_set(fuse_set),
  .locked(locked), .wr_busy(wr_busy), .dirty(dirty)
);

// File: tb/cfg_sec_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_sec_ctrl_bench;
  localparam int AW = 4, DW = 16, WR_CYC = 4;
  logic clk = 0, por_n = 0, rst_n = 0, cmd_valid = 0, abort = 0;
  logic [3:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [DW-1:0] cmd_wdata = 0;
  logic rsp_valid, rsp_err, rsp_ign, prog_mode, io_enable, fuse_set, locked, wr_busy;
  logic [DW-1:0] rsp_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cfg_sec_ctrl #(.AW(AW), .DW(DW), .WR_CYC(WR_CYC)) u_cfg_sec_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .abort(abort), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_ign(rsp_ign), .prog_mode(prog_mode),
    .io_enable(io_enable), .fuse_set(fuse_set), .locked(locked), .wr_busy(wr_busy));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [AW-1:0] a = 0, input logic [DW-1:0] d = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd(4'd4, a, d);
    chk(wr_busy === 1'b1, "R9 busy after write", {31'b0, wr_busy}, 1);
    repeat (WR_CYC) @(negedge clk);
    chk(wr_busy === 1'b0, "R9 busy cleared", {31'b0, wr_busy}, 0);
  endtask

  task automatic verify(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    cmd(4'd5, a);
    chk(rsp_valid && !rsp_err && rsp_data === exp, req, {16'b0, rsp_data}, {16'b0, exp});
  endtask

  task automatic t_reset();
    chk(!rsp_valid && io_enable && !fuse_set && !locked && !prog_mode, "R8 power-up state",
        {27'b0, rsp_valid, io_enable, fuse_set, locked, prog_mode}, 32'h8);
  endtask

  task automatic t_func_ignore();
    cmd(4'd4, 4'd3, 16'h1111);
    chk(rsp_valid && rsp_ign, "R7 write ignored in functional mode", {31'b0, rsp_ign}, 1);
    cmd(4'd8);
    chk(rsp_ign && !fuse_set, "R7 fuse set ignored in functional mode", {30'b0, rsp_ign, fuse_set}, 2);
    cmd(4'hF);
    chk(rsp_ign, "R7 undefined opcode ignored", {31'b0, rsp_ign}, 1);
    cmd(4'd7);
    chk(rsp_valid && !rsp_ign && rsp_data === 16'h0, "R2 signature read in functional mode", {16'b0, rsp_data}, 0);
  endtask

  task automatic t_enter();
    cmd(4'd1);
    chk(prog_mode && !io_enable, "R4 io off in programming mode", {30'b0, prog_mode, io_enable}, 2);
    cmd(4'd1);
    chk(rsp_ign && prog_mode, "R7 enter ignored in programming mode", {31'b0, rsp_ign}, 1);
    verify(4'd3, 16'hFFFF, "R7 ignored write left word 3 erased");
    verify(4'd6, 16'hFFFF, "R8 power-up word reads all ones");
  endtask

  task automatic t_write();
    cmd(4'd4, 4'd5, 16'hA5A5);
    chk(wr_busy, "R9 busy set", {31'b0, wr_busy}, 1);
    cmd(4'd5, 4'd5);
    chk(rsp_ign, "R9 verify during busy ignored", {31'b0, rsp_ign}, 1);
    repeat (WR_CYC - 1) @(negedge clk);
    chk(!wr_busy, "R9 write done after WR_CYC", {31'b0, wr_busy}, 0);
    verify(4'd5, 16'hA5A5, "R9 word 5 written");
    wr_word(4'd0, 16'h0F0F);
    verify(4'd0, 16'h0F0F, "R9 word 0 written");
  endtask

  task automatic t_fuse();
    cmd(4'd6, 0, 16'h1234);
    cmd(4'd8);
    chk(fuse_set, "R3 fuse set", {31'b0, fuse_set}, 1);
    cmd(4'd5, 4'd5);
    chk(rsp_err && rsp_data === 16'h0, "R1 verify refused", {15'b0, rsp_err, rsp_data}, 32'h10000);
    cmd(4'd7);
    chk(rsp_data === 16'h1234 && !rsp_err, "R2 signature readable under fuse", {16'b0, rsp_data}, 32'h1234);
    wr_word(4'd7, 16'h7777);
    chk(fuse_set, "R3 fuse kept after word write", {31'b0, fuse_set}, 1);
    cmd(4'd6, 0, 16'h5678);
    chk(fuse_set, "R3 fuse kept after signature write", {31'b0, fuse_set}, 1);
    cmd(4'd7);
    chk(rsp_data === 16'h5678, "R2 signature writable under fuse", {16'b0, rsp_data}, 32'h5678);
    cmd(4'd2);
    chk(!prog_mode && io_enable && !locked, "R4 clean exit enables io", {30'b0, prog_mode, io_enable}, 1);
    cmd(4'd7);
    chk(rsp_data === 16'h5678, "R2 signature read in functional mode with fuse", {16'b0, rsp_data}, 32'h5678);
  endtask

  task automatic t_erase();
    cmd(4'd1);
    cmd(4'd3);
    chk(!fuse_set, "R3 erase clears fuse", {31'b0, fuse_set}, 0);
    verify(4'd5, 16'hFFFF, "R8 erased word 5");
    verify(4'd7, 16'hFFFF, "R8 erased word 7");
    cmd(4'd7);
    chk(rsp_data === 16'h5678, "R8 erase keeps signature", {16'b0, rsp_data}, 32'h5678);
    cmd(4'd2);
    chk(io_enable, "R4 io back on", {31'b0, io_enable}, 1);
  endtask

  task automatic recover();
    cmd(4'd1);
    cmd(4'd2);
    chk(locked && !io_enable, "R6 lock survives plain exit", {31'b0, locked}, 1);
    cmd(4'd1);
    cmd(4'd3);
    cmd(4'd2);
    chk(locked, "R6 lock survives erase without write", {31'b0, locked}, 1);
    cmd(4'd1);
    cmd(4'd3);
    wr_word(4'd1, 16'hBEEF);
    cmd(4'd2);
    chk(!locked && io_enable, "R6 lock cleared by erase, write, exit", {30'b0, locked, io_enable}, 1);
  endtask

  task automatic t_abort();
    cmd(4'd1);
    do_abort();
    chk(!prog_mode && !locked && io_enable, "R5 clean abort no lock", {29'b0, prog_mode, locked, io_enable}, 1);
    cmd(4'd1);
    wr_word(4'd2, 16'h2222);
    do_abort();
    chk(!prog_mode && locked && !io_enable, "R5 dirty abort locks", {29'b0, prog_mode, locked, io_enable}, 2);
    recover();
  endtask

  task automatic t_warm_reset();
    cmd(4'd1);
    cmd(4'd6, 0, 16'h9999);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(!prog_mode && locked && !io_enable, "R5 warm reset in dirty session locks", {29'b0, prog_mode, locked, io_enable}, 2);
    recover();
  endtask

  task automatic t_exit_busy();
    cmd(4'd1);
    cmd(4'd4, 4'd9, 16'h3333);
    cmd(4'd2);
    chk(!prog_mode && locked && !io_enable, "R5 exit with write outstanding locks", {29'b0, prog_mode, locked, io_enable}, 2);
    recover();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_func_ignore();
    t_enter();
    t_write();
    t_fuse();
    t_erase();
    t_abort();
    t_warm_reset();
    t_exit_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule